// File: doc/BRIEF.md
# GPIO Bank with Polarity-Shared Interrupts

This block is a bank of general-purpose pins behind a plain word-wide register port. Software sets each pin's direction. It reads the synchronized pin levels and drives outputs through a data register. That register can also be changed bit by bit through dedicated set and clear offsets, so no read-modify-write is needed. Reads are combinational from the address. Writes take effect on the clock edge where `req_i` and `we_i` are both high.

Only the low pins raise interrupts, with one active-high line per pin toward a downstream interrupt controller. A pin's output-data bit also chooses its interrupt polarity: 0 selects rising edge or high level, and 1 selects falling edge or low level. A per-pin sense bit picks level or edge detection. A per-pin both-edge bit overrides both the polarity and the sense bit. Edges are latched in a sticky status register that software clears by writing 1s.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads 0, `pin_oe_o` is 0 and `irq_o` is 0.
- R2: Offset 0x00 (direction) and offset 0x10 (output data) are read/write. `pin_oe_o` equals direction (bit 1 = drive the pin). `pin_o` equals output data.
- R3: A write to 0x18 sets the output-data bits that are 1 in the write data, and a write to 0x20 clears them. Bits that are 0 in the write data are left alone. Both offsets read as 0.
- R4: Offset 0x08 returns `pin_i` delayed by a two-flop synchronizer. A level applied before clock edge k is readable after edge k+1. Writes to 0x08 have no effect.
- R5: In level sensing (bit 0 at 0x28 and bit 0 at 0x30), `irq_o[i]` equals the synchronized pin level XOR output-data bit i.
- R6: In edge sensing (bit 1 at 0x28, bit 0 at 0x30), output-data bit 0 latches status on a rising edge and bit 1 latches status on a falling edge. The opposite edge does nothing.
- R7: Both-edge bit 1 at 0x30 latches status on either edge. This holds whatever the output-data bit and the sense bit are.
- R8: Status at 0x38 is sticky. In edge sensing, `irq_o[i]` equals status bit i. Writing 1 clears a bit, and writing 0 leaves it. A new edge in the same cycle as the clearing write wins, and the bit stays set.
- R9: Only pins 0..NIRQ-1 (default 16) have interrupt logic. Bits at and above NIRQ of 0x28, 0x30 and 0x38 read 0, and writes to them are dropped.
- R10: Offsets not listed above read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write enable (with req_i) |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | NPINS | Write data |
| rdata_o | output | NPINS | Read data (combinational) |
| pin_i | input | NPINS | Pin input levels (asynchronous) |
| pin_o | output | NPINS | Pin output values |
| pin_oe_o | output | NPINS | Pin output enables |
| irq_o | output | NIRQ | Active-high interrupt per low pin |

## Verification
Random direction, data and set/clear masks are applied against a bench model. This separates a true bitwise set or clear from an overwrite of the whole register. Random pin vectors are checked in level mode with random polarity, which shows whether the XOR with the data bit is present. Directed rising and falling edges are applied with mixed polarities, first in single-edge mode and then in both-edge mode. These show which edge arms each pin and whether the both-edge bit overrides the polarity. A clearing write is timed into the same cycle as a detected edge to confirm that the set wins.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 8;
  localparam logic [REG_AW-1:0] OFF_DIR   = 8'h00;
  localparam logic [REG_AW-1:0] OFF_IN    = 8'h08;
  localparam logic [REG_AW-1:0] OFF_OUT   = 8'h10;
  localparam logic [REG_AW-1:0] OFF_SET   = 8'h18;
  localparam logic [REG_AW-1:0] OFF_CLR   = 8'h20;
  localparam logic [REG_AW-1:0] OFF_SENSE = 8'h28;
  localparam logic [REG_AW-1:0] OFF_BOTH  = 8'h30;
  localparam logic [REG_AW-1:0] OFF_STAT  = 8'h38;

  typedef struct packed {
    logic dir;
    logic out;
    logic set;
    logic clr;
    logic sense;
    logic both;
    logic stat;
  } wr_sel_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NIRQ  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  sync_i,
  input  logic [NIRQ-1:0]   stat_i,
  output logic [NPINS-1:0]  dir_o,
  output logic [NPINS-1:0]  out_o,
  output logic [NIRQ-1:0]   sense_o,
  output logic [NIRQ-1:0]   both_o,
  output logic [NIRQ-1:0]   stat_clr_o
);
  localparam int DW = NPINS;

  wr_sel_t         sel;
  logic [DW-1:0]   dir_q, out_q;
  logic [NIRQ-1:0] sense_q, both_q;

  always_comb begin
    sel = '0;
    if (req_i && we_i) begin
      case (addr_i)
        OFF_DIR:   sel.dir   = 1'b1;
        OFF_OUT:   sel.out   = 1'b1;
        OFF_SET:   sel.set   = 1'b1;
        OFF_CLR:   sel.clr   = 1'b1;
        OFF_SENSE: sel.sense = 1'b1;
        OFF_BOTH:  sel.both  = 1'b1;
        OFF_STAT:  sel.stat  = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      out_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
    end else begin
      if (sel.dir)   dir_q   <= wdata_i;
      if (sel.out)   out_q   <= wdata_i;
      else if (sel.set) out_q <= out_q | wdata_i;
      else if (sel.clr) out_q <= out_q & ~wdata_i;
      if (sel.sense) sense_q <= wdata_i[NIRQ-1:0];
      if (sel.both)  both_q  <= wdata_i[NIRQ-1:0];
    end
  end

  assign stat_clr_o = sel.stat ? wdata_i[NIRQ-1:0] : '0;

  always_comb begin
    case (addr_i)
      OFF_DIR:   rdata_o = dir_q;
      OFF_IN:    rdata_o = sync_i;
      OFF_OUT:   rdata_o = out_q;
      OFF_SENSE: rdata_o = DW'(sense_q);
      OFF_BOTH:  rdata_o = DW'(both_q);
      OFF_STAT:  rdata_o = DW'(stat_i);
      default:   rdata_o = '0;
    endcase
  end

  assign dir_o   = dir_q;
  assign out_o   = out_q;
  assign sense_o = sense_q;
  assign both_o  = both_q;

  assert_oset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_SET) |=> ((out_q & $past(wdata_i)) == $past(wdata_i)));
  assert_oclr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == OFF_CLR) |=> ((out_q & $past(wdata_i)) == '0));
  assert_dir_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i && addr_i == OFF_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
  parameter int NIRQ = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NIRQ-1:0] lvl_i,
  input  logic [NIRQ-1:0] pol_i,
  input  logic [NIRQ-1:0] sense_i,
  input  logic [NIRQ-1:0] both_i,
  input  logic [NIRQ-1:0] clr_i,
  output logic [NIRQ-1:0] stat_o,
  output logic [NIRQ-1:0] irq_o
);
  logic [NIRQ-1:0] prev_q, stat_q, stat_d, hit;

  for (genvar g = 0; g < NIRQ; g++) begin : g_pin
    logic edge_mode, rise, fall;
    assign edge_mode = sense_i[g] | both_i[g];
    assign rise      = lvl_i[g] & ~prev_q[g];
    assign fall      = ~lvl_i[g] & prev_q[g];
    assign hit[g]    = edge_mode &
                       (both_i[g] ? (rise | fall) : (pol_i[g] ? fall : rise));
    // a fresh edge beats a same-cycle clear
    assign stat_d[g] = hit[g] | (stat_q[g] & ~clr_i[g]);
    assign irq_o[g]  = edge_mode ? stat_q[g] : (lvl_i[g] ^ pol_i[g]);

    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[g] && !clr_i[g]) |=> stat_q[g]);
    assert_set_needs_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(stat_q[g]) |-> ($past(lvl_i[g]) != $past(prev_q[g])));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int NIRQ  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic [NIRQ-1:0]   irq_o
);
  logic [NPINS-1:0] sync_w, dir_w, out_w;
  logic [NIRQ-1:0]  sense_w, both_w, clr_w, stat_w;

  gpio_sync #(.W(NPINS)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync_w)
  );

  gpio_regs #(.NPINS(NPINS), .NIRQ(NIRQ)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .sync_i    (sync_w),
    .stat_i    (stat_w),
    .dir_o     (dir_w),
    .out_o     (out_w),
    .sense_o   (sense_w),
    .both_o    (both_w),
    .stat_clr_o(clr_w)
  );

  gpio_irq_unit #(.NIRQ(NIRQ)) i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_w[NIRQ-1:0]),
    .pol_i  (out_w[NIRQ-1:0]),
    .sense_i(sense_w),
    .both_i (both_w),
    .clr_i  (clr_w),
    .stat_o (stat_w),
    .irq_o  (irq_o)
  );

  assign pin_o    = out_w;
  assign pin_oe_o = dir_w;

  assert_in_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == OFF_IN) |-> (rdata_o == sync_w));
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int NP = 32;
  localparam int NI = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req, we;
  logic [7:0]    addr;
  logic [NP-1:0] wdata, rdata, pins, pin_o, pin_oe;
  logic [NI-1:0] irq;

  int checks = 0, fails = 0;
  logic [31:0] m_od, m_dir;

  always #10 clk = ~clk;

  gpio_irq_bank #(.NPINS(NP), .NIRQ(NI)) i_gpio_irq_bank (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  function automatic logic [15:0] lvl_irq(input logic [31:0] p, input logic [31:0] od);
    return p[15:0] ^ od[15:0];
  endfunction

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, m;
    void'($urandom(32'h5eed_0017));
    req = 0; we = 0; addr = 0; wdata = 0; pins = 0; m_od = 0; m_dir = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 8), v);
      chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 oe reset", pin_oe, 32'h0);
    chk("R1 irq reset", 32'(irq), 32'h0);

    // R2 direction and data
    for (int i = 0; i < 8; i++) begin
      m_dir = $urandom; m_od = $urandom;
      wr(8'h00, m_dir); wr(8'h10, m_od);
      rd(8'h00, v); chk("R2 dir readback", v, m_dir);
      rd(8'h10, v); chk("R2 out readback", v, m_od);
      chk("R2 pin_oe_o", pin_oe, m_dir);
      chk("R2 pin_o", pin_o, m_od);
    end

    // R3 atomic set / clear
    for (int i = 0; i < 10; i++) begin
      m = $urandom;
      if (i % 2 == 0) begin wr(8'h18, m); m_od = m_od | m; end
      else begin wr(8'h20, m); m_od = m_od & ~m; end
      rd(8'h10, v); chk("R3 set/clr result", v, m_od);
      rd(8'h18, v); chk("R3 set reads 0", v, 32'h0);
      rd(8'h20, v); chk("R3 clr reads 0", v, 32'h0);
    end

    // R4 sync latency
    pins = 32'hA5A5_0F0F;
    tick(1); rd(8'h08, v); chk("R4 after 1 edge old", v, 32'h0);
    tick(1); rd(8'h08, v); chk("R4 after 2 edges new", v, 32'hA5A5_0F0F);
    for (int i = 0; i < 6; i++) begin
      pins = $urandom; tick(3);
      wr(8'h08, $urandom);
      rd(8'h08, v); chk("R4 input data", v, pins);
    end

    // R5 level sensing
    wr(8'h28, 0); wr(8'h30, 0);
    for (int i = 0; i < 8; i++) begin
      pins = $urandom; m_od = $urandom; wr(8'h10, m_od); tick(3);
      chk("R5 level irq", 32'(irq), 32'(lvl_irq(pins, m_od)));
    end

    // R6 single-edge, pins 0..7 falling, 8..15 rising
    pins = 0; m_od = 32'h0000_00FF; wr(8'h10, m_od); tick(3);
    wr(8'h28, 32'hFFFF); wr(8'h38, 32'hFFFF);
    chk("R6 status clear", 32'(irq), 32'h0);
    pins = 32'h0000_FFFF; tick(4);
    rd(8'h38, v); chk("R6 rising only", v, 32'h0000_FF00);
    chk("R6 irq follows status", 32'(irq), 32'hFF00);
    wr(8'h38, 32'hFFFF);
    pins = 0; tick(4);
    rd(8'h38, v); chk("R6 falling only", v, 32'h0000_00FF);
    wr(8'h38, 32'hFFFF);

    // R7 both edges, overriding polarity and sense
    wr(8'h28, 0); wr(8'h30, 32'hFFFF); tick(2);
    rd(8'h38, v); chk("R7 no spurious", v, 32'h0);
    m = $urandom & 32'hFFFF;
    pins = m; tick(4);
    rd(8'h38, v); chk("R7 rise any pol", v, m);
    wr(8'h38, 32'hFFFF);
    pins = 0; tick(4);
    rd(8'h38, v); chk("R7 fall any pol", v, m);
    chk("R7 irq", 32'(irq), m);

    // R8 sticky, W1C, set wins
    wr(8'h38, 32'h0);
    rd(8'h38, v); chk("R8 write 0 keeps", v, m);
    wr(8'h38, m & 32'h00FF);
    rd(8'h38, v); chk("R8 partial clear", v, m & 32'hFF00);
    wr(8'h38, 32'hFFFF); wr(8'h30, 0); wr(8'h28, 32'hFFFF);
    wr(8'h10, 0); m_od = 0;
    pins = 32'h1; tick(2);
    wr(8'h38, 32'h1);
    rd(8'h38, v); chk("R8 set wins over clear", v, 32'h1);
    wr(8'h38, 32'h1);
    rd(8'h38, v); chk("R8 cleared", v, 32'h0);
    chk("R8 irq low after clear", 32'(irq), 32'h0);

    // R9 upper bits
    wr(8'h28, 32'hFFFF_FFFF); wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h28, v); chk("R9 sense upper", v, 32'h0000_FFFF);
    rd(8'h30, v); chk("R9 both upper", v, 32'h0000_FFFF);
    pins = 32'hFFFF_0001; tick(4);
    rd(8'h38, v); chk("R9 status upper", v, 32'h0);

    // R10 unmapped offsets
    wr(8'h00, 32'h1234_5678); m_dir = 32'h1234_5678;
    wr(8'h04, $urandom); wr(8'h3C, $urandom); wr(8'h40, $urandom);
    rd(8'h04, v); chk("R10 unmapped 04", v, 32'h0);
    rd(8'h40, v); chk("R10 unmapped 40", v, 32'h0);
    rd(8'h00, v); chk("R10 dir unchanged", v, m_dir);
    rd(8'h10, v); chk("R10 out unchanged", v, m_od);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule